// File: doc/BRIEF.md
# Seconds Counter with Alarm Interrupt

This peripheral keeps wall-clock time as a 32-bit count of seconds. A one-cycle tick input, produced once per second by an external prescaler, advances the count while the run bit in the control register is set. Software presets the time through a load register and reads it back through a separate read-only time register. It arms an alarm by writing a match value.

When the count steps onto the match value, an alarm status bit latches. The interrupt side uses a split model. The raw status is always visible. A mask register selects which raw bits may reach the interrupt line. A masked status register shows what is actually driving that line. Writing ones to a clear register acknowledges pending status. The block sits on a simple two-phase register bus with select, enable and write strobes and no wait states.

Top module: `rtc_alarm_periph`

## Requirements
- R1: After synchronous reset the count, match, load readback, run bit, mask and raw status are all zero, every register reads zero and `alarm_irq` is low.
- R2: The count rises by exactly one on each clock edge where `sec_tick` is high and the run bit (control register offset 0x0C, bit 26) is 1. It holds its value when either is low.
- R3: A write to the load register (offset 0x08) replaces the count with the written word on that edge, overriding a tick in the same cycle. The time register (offset 0x00) reads the current count, and offset 0x08 reads back the last loaded word.
- R4: The match register (offset 0x04) is read/write. Raw alarm status (offset 0x14, bit 0) sets on the tick edge where the incremented count equals the match value. A load that makes the count equal to the match value does not set it.
- R5: Masked status (offset 0x18, bit 0) equals raw status AND mask (offset 0x10, bit 0), and `alarm_irq` is high exactly when a masked bit is set.
- R6: With the mask bit at 0, a pending alarm reads as 1 in raw status while masked status and `alarm_irq` stay 0.
- R7: Writing bit 0 = 1 to the clear register (offset 0x1C) clears the raw alarm bit. Writing 0 to bit 0 leaves it unchanged, whatever the other bits hold.
- R8: When an alarm set and a clear write fall on the same edge, the raw alarm bit ends up set.
- R9: Reads of unmapped offsets (0x20 and above, or addresses with a nonzero byte offset) and of the clear register return zero. Writes to the read-only offsets 0x00, 0x14 and 0x18 and to unmapped offsets change no state.
- R10: The count wraps from 0xFFFFFFFF to 0 on a tick, and a match value of 0 raises the alarm on that wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sec_tick | input | 1 | One-cycle pulse per second from the prescaler |
| bus_sel | input | 1 | Peripheral select |
| bus_en | input | 1 | Access phase strobe; a transfer completes on a cycle with select and enable high |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (12) | Byte address of the register |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data, valid while a read is selected |
| alarm_irq | output | 1 | Level interrupt, high while any masked status bit is set |

## Verification
Two pairs of events can share a clock edge: a tick that lands the count on the match value together with a clear write, and a tick together with a load write. The bench provokes both by holding the count one below the match value and raising `sec_tick` exactly during the access phase of the clear or load transfer. It then reads raw status and the time register and expects the alarm to survive and the loaded word to win over the increment. A behavioural reference model runs beside the design through a long stretch of random ticks and random register traffic. The model updates on every edge, every read is compared with it, and the interrupt line is compared with it on every clock.

// File: rtl/rtc_alarm_pkg.sv
// Package: shared constants and register index type for the seconds
// counter with alarm. Assumes word-aligned registers, eight per block.
package rtc_alarm_pkg;

    // Word index of each register within the block (byte offset / 4).
    typedef enum logic [2:0] {
        IDX_TIME  = 3'd0,
        IDX_MATCH = 3'd1,
        IDX_LOAD  = 3'd2,
        IDX_CTRL  = 3'd3,
        IDX_MASK  = 3'd4,
        IDX_RAW   = 3'd5,
        IDX_MSTAT = 3'd6,
        IDX_CLEAR = 3'd7
    } reg_idx_e;

    localparam int unsigned NUM_REGS  = 8;
    localparam int unsigned IDX_W     = 3;
    localparam int unsigned RUN_BIT   = 26;
    localparam int unsigned ALARM_BIT = 0;

endpackage

// File: rtl/rtc_bus_decode.sv
// Module: rtc_bus_decode
// Turns the two-phase register bus into one write strobe per register
// and a decoded read index. Assumes zero wait states: a transfer
// completes on the cycle where select and enable are both high.
// Addresses outside the eight-word window or with a nonzero byte
// offset produce no strobe and a read miss.
module rtc_bus_decode
    import rtc_alarm_pkg::*;
#(
    parameter int unsigned ADDR_W = 12
) (
    input  logic              bus_sel,
    input  logic              bus_en,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic [NUM_REGS-1:0] wr_stb,
    output logic              rd_hit,
    output logic [IDX_W-1:0]  rd_idx
);
    localparam int unsigned HI_LSB = IDX_W + 2;

    logic             in_window;
    logic             access;
    logic [IDX_W-1:0] word_idx;

    // Window check: upper address bits and byte offset must be zero.
    always_comb begin
        word_idx  = bus_addr[HI_LSB-1:2];
        in_window = (bus_addr[ADDR_W-1:HI_LSB] == '0) && (bus_addr[1:0] == 2'b00);
        access    = bus_sel && bus_en;
    end

    // One strobe per register index, repeated by generate.
    for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_stb
        assign wr_stb[gi] = access && bus_write && in_window && (word_idx == IDX_W'(gi));
    end

    // Read decode is valid through both phases of a read.
    assign rd_hit = bus_sel && !bus_write && in_window;
    assign rd_idx = word_idx;

endmodule

// File: rtl/rtc_cfg_regs.sv
// Module: rtc_cfg_regs
// Holds the software-written configuration: match value, last loaded
// time word, run bit and interrupt mask. Assumes write strobes arrive
// one-hot from the decoder. Writes to other indices leave it untouched.
module rtc_cfg_regs
    import rtc_alarm_pkg::*;
#(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned NUM_IRQ = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_REGS-1:0] wr_stb,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   match_q,
    output logic [DATA_W-1:0]   load_q,
    output logic                run_q,
    output logic [NUM_IRQ-1:0]  mask_q
);

    // Match register: full-word read/write.
    always_ff @(posedge clk) begin
        if (!rst_n)                 match_q <= '0;
        else if (wr_stb[IDX_MATCH]) match_q <= wdata;
    end

    // Load readback copy: remembers the last word written to the load slot.
    always_ff @(posedge clk) begin
        if (!rst_n)                load_q <= '0;
        else if (wr_stb[IDX_LOAD]) load_q <= wdata;
    end

    // Run bit: the only implemented field of the control register.
    always_ff @(posedge clk) begin
        if (!rst_n)                run_q <= 1'b0;
        else if (wr_stb[IDX_CTRL]) run_q <= wdata[RUN_BIT];
    end

    // Interrupt mask: one bit per interrupt source.
    always_ff @(posedge clk) begin
        if (!rst_n)                mask_q <= '0;
        else if (wr_stb[IDX_MASK]) mask_q <= wdata[NUM_IRQ-1:0];
    end

endmodule

// File: rtl/rtc_sec_counter.sv
// Module: rtc_sec_counter
// The seconds counter and its comparator. A load write takes priority
// over a tick. The match event fires only when an increment lands the
// count on the match value, never on a load. Wraps modulo 2**CNT_W.
module rtc_sec_counter #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             run,
    input  logic             load_we,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] match_val,
    output logic [CNT_W-1:0] count_q,
    output logic             match_hit
);
    logic [CNT_W-1:0] count_inc;
    logic             step;

    // Increment value and the qualified step condition.
    always_comb begin
        count_inc = count_q + CNT_W'(1);
        step      = tick && run && !load_we;
        match_hit = step && (count_inc == match_val);
    end

    // Counter register: load, step, or hold.
    always_ff @(posedge clk) begin
        if (!rst_n)       count_q <= '0;
        else if (load_we) count_q <= load_val;
        else if (step)    count_q <= count_inc;
    end

    // R2: without a qualified tick and with no load, the count holds.
    a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_we && !(tick && run)) |=> $stable(count_q));

    // R2: a qualified tick advances the count by exactly one.
    a_r2_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_we && tick && run) |=> (count_q == $past(count_q) + CNT_W'(1)));

    // R3: a load write wins over any tick on the same edge.
    a_r3_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        load_we |=> (count_q == $past(load_val)));

endmodule

// File: rtl/rtc_alarm_irq.sv
// Module: rtc_alarm_irq
// Raw status latch, masked status and the interrupt line. A set event
// in the same cycle as a clear of the same bit leaves the bit set.
// Assumes set and clear are single-cycle qualified pulses.
module rtc_alarm_irq #(
    parameter int unsigned NUM_IRQ = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] set_evt,
    input  logic [NUM_IRQ-1:0] clr_evt,
    input  logic [NUM_IRQ-1:0] mask,
    output logic [NUM_IRQ-1:0] raw_q,
    output logic [NUM_IRQ-1:0] masked,
    output logic               irq
);

    // Raw status: per-bit latch, set beats clear.
    for (genvar gb = 0; gb < NUM_IRQ; gb++) begin : g_raw
        always_ff @(posedge clk) begin
            if (!rst_n)           raw_q[gb] <= 1'b0;
            else if (set_evt[gb]) raw_q[gb] <= 1'b1;
            else if (clr_evt[gb]) raw_q[gb] <= 1'b0;
        end
    end

    // Masked view and the combined interrupt line.
    always_comb begin
        masked = raw_q & mask;
        irq    = |masked;
    end

    // R8: a set event leaves its bit high even when cleared on the same edge.
    a_r8_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (set_evt != '0) |=> ((raw_q & $past(set_evt)) == $past(set_evt)));

    // R7: a clear with no competing set drops the bit.
    a_r7_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_evt & ~set_evt) != '0) |=> ((raw_q & $past(clr_evt & ~set_evt)) == '0));

    // R7: bits neither set nor cleared keep their value.
    a_r7_untouched_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_evt | clr_evt) == '0) |=> $stable(raw_q));

endmodule

// File: rtl/rtc_alarm_periph.sv
// Module: rtc_alarm_periph (top)
// Bus-mapped seconds counter with a match alarm and a split interrupt
// model. Assumes a one-cycle sec_tick from an external prescaler and a
// zero-wait-state two-phase register bus. Read data is a combinational
// mux of the register state and is zero on a read miss.
module rtc_alarm_periph
    import rtc_alarm_pkg::*;
#(
    parameter int unsigned ADDR_W  = 12,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned NUM_IRQ = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_tick,
    input  logic              bus_sel,
    input  logic              bus_en,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              alarm_irq
);
    logic [NUM_REGS-1:0] wr_stb;
    logic                rd_hit;
    logic [IDX_W-1:0]    rd_idx;
    logic [DATA_W-1:0]   match_q;
    logic [DATA_W-1:0]   load_q;
    logic                run_q;
    logic [NUM_IRQ-1:0]  mask_q;
    logic [DATA_W-1:0]   count_q;
    logic                match_hit;
    logic [NUM_IRQ-1:0]  set_vec;
    logic [NUM_IRQ-1:0]  clr_vec;
    logic [NUM_IRQ-1:0]  raw_q;
    logic [NUM_IRQ-1:0]  masked;

    rtc_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
        .bus_sel   (bus_sel),
        .bus_en    (bus_en),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .wr_stb    (wr_stb),
        .rd_hit    (rd_hit),
        .rd_idx    (rd_idx)
    );

    rtc_cfg_regs #(.DATA_W(DATA_W), .NUM_IRQ(NUM_IRQ)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_stb  (wr_stb),
        .wdata   (bus_wdata),
        .match_q (match_q),
        .load_q  (load_q),
        .run_q   (run_q),
        .mask_q  (mask_q)
    );

    rtc_sec_counter #(.CNT_W(DATA_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (sec_tick),
        .run       (run_q),
        .load_we   (wr_stb[IDX_LOAD]),
        .load_val  (bus_wdata),
        .match_val (match_q),
        .count_q   (count_q),
        .match_hit (match_hit)
    );

    // Route the alarm to its status bit and the clear-register bits to clears.
    always_comb begin
        set_vec            = '0;
        set_vec[ALARM_BIT] = match_hit;
        clr_vec            = wr_stb[IDX_CLEAR] ? bus_wdata[NUM_IRQ-1:0] : '0;
    end

    rtc_alarm_irq #(.NUM_IRQ(NUM_IRQ)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_evt (set_vec),
        .clr_evt (clr_vec),
        .mask    (mask_q),
        .raw_q   (raw_q),
        .masked  (masked),
        .irq     (alarm_irq)
    );

    // Read mux: one word per index, zero on a miss or a write-only slot.
    always_comb begin
        bus_rdata = '0;
        if (rd_hit) begin
            unique case (reg_idx_e'(rd_idx))
                IDX_TIME:  bus_rdata = count_q;
                IDX_MATCH: bus_rdata = match_q;
                IDX_LOAD:  bus_rdata = load_q;
                IDX_CTRL:  bus_rdata[RUN_BIT] = run_q;
                IDX_MASK:  bus_rdata[NUM_IRQ-1:0] = mask_q;
                IDX_RAW:   bus_rdata[NUM_IRQ-1:0] = raw_q;
                IDX_MSTAT: bus_rdata[NUM_IRQ-1:0] = masked;
                IDX_CLEAR: bus_rdata = '0;
                default:   bus_rdata = '0;
            endcase
        end
    end

    // R4: the alarm bit only rises when the new count equals the match value in force.
    a_r4_rise_on_match: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(raw_q[ALARM_BIT]) |-> (count_q == $past(match_q)));

    // R6: with the mask clear the interrupt line stays low whatever raw holds.
    a_r6_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !alarm_irq);

endmodule

// File: tb/rtc_alarm_periph_test.sv
// Bench for rtc_alarm_periph: behavioural reference model updated on
// every edge, compared on every read and on the interrupt line each clock.
module rtc_alarm_periph_test;
    localparam int AW = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sec_tick = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_write = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        alarm_irq;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit rand_ticks = 1'b0;
    bit model_live = 1'b0;

    // Reference model state.
    logic [31:0] m_cnt = '0, m_match = '0, m_load = '0;
    logic        m_run = 1'b0, m_mask = 1'b0, m_raw = 1'b0;

    rtc_alarm_periph uut (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick),
        .bus_sel(bus_sel), .bus_en(bus_en), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .alarm_irq(alarm_irq)
    );

    always #2 clk = ~clk;   // 250 MHz

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", tag, act, exp, $time);
        end
    endtask

    // Model update on each edge.
    always @(posedge clk) begin
        logic wr, ld, hit, clr;
        int idx;
        logic [31:0] nxt;
        model_live <= 1'b1;
        if (!rst_n) begin
            m_cnt <= 0; m_match <= 0; m_load <= 0;
            m_run <= 0; m_mask <= 0; m_raw <= 0;
        end else begin
            wr  = bus_sel && bus_en && bus_write && (bus_addr < 12'h20) && (bus_addr % 4 == 0);
            idx = int'(bus_addr) / 4;
            ld  = wr && idx == 2;
            hit = 1'b0;
            nxt = m_cnt;
            if (ld) nxt = bus_wdata;
            else if (sec_tick && m_run) begin
                nxt = m_cnt + 1;
                hit = (nxt == m_match);
            end
            clr = wr && idx == 7 && bus_wdata[0];
            m_cnt <= nxt;
            if (hit) m_raw <= 1'b1;
            else if (clr) m_raw <= 1'b0;
            if (wr && idx == 1) m_match <= bus_wdata;
            if (ld) m_load <= bus_wdata;
            if (wr && idx == 3) m_run <= bus_wdata[26];
            if (wr && idx == 4) m_mask <= bus_wdata[0];
        end
    end

    function automatic logic [31:0] model_read(input logic [AW-1:0] a);
        if (a >= 12'h20 || a[1:0] != 2'b00) return 32'h0;
        case (a[4:2])
            3'd0: return m_cnt;
            3'd1: return m_match;
            3'd2: return m_load;
            3'd3: return {5'b0, m_run, 26'b0};
            3'd4: return {31'b0, m_mask};
            3'd5: return {31'b0, m_raw};
            3'd6: return {31'b0, m_raw & m_mask};
            default: return 32'h0;
        endcase
    endfunction

    // R5: interrupt line against the model on every clock.
    always @(negedge clk) begin
        if (model_live && rst_n) check("R5 irq", {31'b0, alarm_irq}, {31'b0, m_raw & m_mask});
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles == 150000) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    function automatic logic rnd_tick();
        return rand_ticks ? logic'($urandom_range(0, 1)) : 1'b0;
    endfunction

    task automatic bus_wr(input logic [AW-1:0] a, input logic [31:0] d, input bit tick_access = 0);
        @(negedge clk);
        bus_sel = 1; bus_en = 0; bus_write = 1; bus_addr = a; bus_wdata = d; sec_tick = rnd_tick();
        @(negedge clk);
        bus_en = 1; sec_tick = tick_access ? 1'b1 : rnd_tick();
        @(negedge clk);
        bus_sel = 0; bus_en = 0; bus_write = 0; sec_tick = rnd_tick();
    endtask

    task automatic bus_rd(input logic [AW-1:0] a, input string tag);
        @(negedge clk);
        bus_sel = 1; bus_en = 0; bus_write = 0; bus_addr = a; sec_tick = rnd_tick();
        @(negedge clk);
        bus_en = 1; sec_tick = rnd_tick();
        #1 check(tag, bus_rdata, model_read(a));
        @(negedge clk);
        bus_sel = 0; bus_en = 0; sec_tick = rnd_tick();
    endtask

    // Read and also compare with a constant taken from the requirement.
    task automatic bus_rd_exp(input logic [AW-1:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_sel = 1; bus_en = 0; bus_write = 0; bus_addr = a; sec_tick = 0;
        @(negedge clk);
        bus_en = 1;
        #1 check(tag, bus_rdata, exp);
        check({tag, " model"}, bus_rdata, model_read(a));
        @(negedge clk);
        bus_sel = 0; bus_en = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            sec_tick = rnd_tick();
        end
    endtask

    task automatic pulse(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); sec_tick = 1;
            @(negedge clk); sec_tick = 0;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state of every register.
        for (int a = 0; a < 32; a += 4) bus_rd_exp(AW'(a), 32'h0, "R1 reset read");
        check("R1 irq after reset", {31'b0, alarm_irq}, 32'h0);
        // R9: unmapped reads.
        bus_rd_exp(12'h020, 32'h0, "R9 unmapped 0x20");
        bus_rd_exp(12'hFFC, 32'h0, "R9 unmapped 0xFFC");
        // R3: load and readback.
        bus_wr(12'h008, 32'h100);
        bus_rd_exp(12'h000, 32'h100, "R3 time after load");
        bus_rd_exp(12'h008, 32'h100, "R3 load readback");
        // R2: run with random ticks, then stop.
        bus_wr(12'h00C, 32'h0400_0000);
        bus_rd_exp(12'h00C, 32'h0400_0000, "R2 run bit");
        rand_ticks = 1; idle(40); rand_ticks = 0;
        bus_rd(12'h000, "R2 count after ticks");
        bus_wr(12'h00C, 32'h0);
        bus_wr(12'h008, 32'h200);
        pulse(5);
        bus_rd_exp(12'h000, 32'h200, "R2 hold when stopped");
        // R9: writes to read-only and unmapped slots change nothing.
        bus_wr(12'h000, 32'h5);
        bus_wr(12'h014, 32'hFFFF_FFFF);
        bus_wr(12'h018, 32'hFFFF_FFFF);
        bus_wr(12'h041, 32'hFFFF_FFFF);
        bus_wr(12'h00D, 32'h0);
        bus_rd_exp(12'h000, 32'h200, "R9 time unchanged");
        bus_rd_exp(12'h014, 32'h0, "R9 raw unchanged");
        bus_rd_exp(12'h040, 32'h0, "R9 unmapped still zero");
        // R4/R6: alarm with the mask clear.
        bus_wr(12'h010, 32'h0);
        bus_wr(12'h008, 32'd10);
        bus_wr(12'h004, 32'd13);
        bus_rd_exp(12'h004, 32'd13, "R4 match readback");
        bus_wr(12'h00C, 32'h0400_0000);
        pulse(2);
        bus_rd_exp(12'h014, 32'h0, "R4 no alarm before match");
        pulse(1);
        bus_rd_exp(12'h014, 32'h1, "R4 alarm at match");
        bus_rd_exp(12'h018, 32'h0, "R6 masked stays zero");
        check("R6 irq low with mask clear", {31'b0, alarm_irq}, 32'h0);
        // R5: unmask.
        bus_wr(12'h010, 32'h1);
        bus_rd_exp(12'h018, 32'h1, "R5 masked status");
        check("R5 irq high", {31'b0, alarm_irq}, 32'h1);
        // R7: clear with bit 0 at zero, then one.
        bus_wr(12'h01C, 32'h0);
        bus_rd_exp(12'h014, 32'h1, "R7 zero write keeps raw");
        bus_wr(12'h01C, 32'hFFFF_FFFE);
        bus_rd_exp(12'h014, 32'h1, "R7 other bits keep raw");
        bus_wr(12'h01C, 32'h1);
        bus_rd_exp(12'h014, 32'h0, "R7 clear drops raw");
        check("R7 irq low after clear", {31'b0, alarm_irq}, 32'h0);
        bus_rd_exp(12'h01C, 32'h0, "R9 clear reads zero");
        // R4: load onto the match value does not raise the alarm.
        bus_wr(12'h008, 32'd13);
        bus_rd_exp(12'h014, 32'h0, "R4 load does not set");
        // R8: tick reaching match in the same edge as a clear write.
        bus_wr(12'h008, 32'd12);
        bus_wr(12'h01C, 32'h1, 1);
        bus_rd_exp(12'h000, 32'd13, "R8 count reached match");
        bus_rd_exp(12'h014, 32'h1, "R8 set beats clear");
        // R3: load in the same edge as a tick.
        bus_wr(12'h008, 32'd500, 1);
        bus_rd_exp(12'h000, 32'd500, "R3 load beats tick");
        // R10: wrap to zero with match at zero.
        bus_wr(12'h01C, 32'h1);
        bus_wr(12'h004, 32'h0);
        bus_wr(12'h008, 32'hFFFF_FFFF);
        pulse(1);
        bus_rd_exp(12'h000, 32'h0, "R10 wrap to zero");
        bus_rd_exp(12'h014, 32'h1, "R10 alarm on wrap");
        // Mixed random traffic against the model.
        rand_ticks = 1;
        for (int k = 0; k < 300; k++) begin
            logic [AW-1:0] a;
            logic [31:0] d;
            a = AW'($urandom_range(0, 9) * 4);
            d = $urandom;
            if (a == 12'h004 || a == 12'h008) d = $urandom_range(0, 40);
            if (a == 12'h00C) d = {5'b0, d[0], 26'b0};
            if ($urandom_range(0, 1) == 0) bus_wr(a, d);
            else bus_rd(a, "R2 R4 R5 random read");
        end
        rand_ticks = 0;
        idle(2);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule